// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block is a small data cache placed between a processor load/store port and a block-wide main-memory port. Each request carries a byte address, a read/write flag, a byte mask and write data, and is taken with a valid/ready handshake. The byte address is split into a word offset, a set index and a tag. The tag is compared against every way of the indexed set. On a read hit the selected word is returned one cycle after acceptance. On a write hit, only the masked bytes of the cached copy change and the frame is marked dirty.

On a miss the cache chooses a frame in the set. An empty frame is always used first; when the set is full, a free-running pseudo-random generator picks the frame. A dirty victim is first copied to memory, and a clean one is simply overwritten. The missing block is then fetched as a whole. The request is then replayed against the refreshed set, so read misses and write misses (write-allocate) complete through the same hit path.

Top module: `wb_cache`

## Requirements
- R1: After reset every frame is invalid and clean, `req_ready` is 1, `resp_valid` is 0 and `mem_req` is 0; `resp_valid` never stays high for two cycles in a row.
- R2: With 16-byte blocks and 4 sets, the set is (address / 16) mod 4 and the tag is the remaining upper bits; two blocks of one set sit in different ways and both hit afterwards.
- R3: A read hit raises `resp_valid` in the first cycle after acceptance, with the addressed 64-bit word (word 0 or 1 of the block, chosen by address bit 3), and issues no memory request.
- R4: A write changes only byte i of the addressed word for each set bit i of `req_be`; every other byte of the block keeps its value.
- R5: A write hit completes in the first cycle after acceptance and causes no memory traffic; the block becomes dirty.
- R6: A read miss fetches the block at block address (address / 16) and returns the freshly filled word; `req_ready` stays 0 from acceptance until the response.
- R7: A write miss fills the block from memory first, then merges the masked bytes into it and marks it dirty, with no write to memory when the victim is clean.
- R8: A dirty victim is written to memory exactly once, at its own block address and with its cached contents, before the fill request for the new block.
- R9: A clean victim is replaced without any memory write.
- R10: When the set has an invalid way, the new block goes there, so no resident block of that set is evicted.
- R11: Once raised, `mem_req` holds its address and direction unchanged until `mem_ready` is seen.
- R12: Under any mix of reads and writes, each read returns the most recent data written to that byte address, or the initial memory contents if no write has reached it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | WORD_BYTES | Byte mask for stores |
| req_wdata | input | 8*WORD_BYTES | Store data |
| resp_valid | output | 1 | Request completed (one-cycle pulse) |
| resp_rdata | output | 8*WORD_BYTES | Load data, valid with resp_valid |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = write block to memory, 0 = fetch |
| mem_addr | output | ADDR_W-log2(block bytes) | Block address |
| mem_wdata | output | 8*WORD_BYTES*BLK_WORDS | Block written back |
| mem_ready | input | 1 | Transfer done; fetch data valid this cycle |
| mem_rdata | input | 8*WORD_BYTES*BLK_WORDS | Fetched block |

## Verification
The bench first fills a set with two clean blocks and then forces a third one in. A cache that evicted while a way was still free would miss on the earlier block, and one that wrote back a clean block would show memory writes where none are expected. It then fills a second set with dirty write-allocated blocks and forces a replacement. Exactly one write is allowed, and it must carry one of the two dirty blocks. Losing the write-back or merging before the fill corrupts the later read-back. Partial-mask stores to both words of a block catch a merge that touches the wrong bytes or the wrong word. A long random mix over sixteen blocks crossing four sets catches wrong index or tag slicing, because aliasing blocks would return stale data.

// File: rtl/wb_cache.sv
module wb_cache #(
  parameter int ADDR_W     = 16,
  parameter int WORD_BYTES = 8,
  parameter int BLK_WORDS  = 2,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic                                req_write,
  input  logic [ADDR_W-1:0]                   req_addr,
  input  logic [WORD_BYTES-1:0]               req_be,
  input  logic [8*WORD_BYTES-1:0]             req_wdata,
  output logic                                resp_valid,
  output logic [8*WORD_BYTES-1:0]             resp_rdata,
  output logic                                mem_req,
  output logic                                mem_we,
  output logic [ADDR_W-$clog2(WORD_BYTES*BLK_WORDS)-1:0] mem_addr,
  output logic [8*WORD_BYTES*BLK_WORDS-1:0]   mem_wdata,
  input  logic                                mem_ready,
  input  logic [8*WORD_BYTES*BLK_WORDS-1:0]   mem_rdata
);
  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int BLK_W  = WORD_W * BLK_WORDS;
  localparam int OFF_W  = $clog2(WORD_BYTES * BLK_WORDS);
  localparam int BO_W   = $clog2(WORD_BYTES);
  localparam int BA_W   = ADDR_W - OFF_W;
  localparam int TAG_W  = BA_W - $clog2(SETS);
  localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int WSEL_W = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_TAG, S_WB, S_FILL} st_t;
  st_t state;

  logic [WAYS-1:0]  vld [SETS];
  logic [WAYS-1:0]  drt [SETS];
  logic [TAG_W-1:0] tags [SETS][WAYS];
  logic [BLK_W-1:0] data [SETS][WAYS];

  logic                  r_we;
  logic [ADDR_W-1:0]     r_addr;
  logic [WORD_BYTES-1:0] r_be;
  logic [WORD_W-1:0]     r_wd;
  logic [WAY_W-1:0]      vic;
  logic [15:0]           lfsr;

  logic [BA_W-1:0]   r_ba;
  logic [IDX_W-1:0]  r_idx;
  logic [TAG_W-1:0]  r_tag;
  logic [WSEL_W-1:0] r_wsel;

  assign r_ba   = r_addr[ADDR_W-1:OFF_W];
  assign r_idx  = IDX_W'(r_ba % BA_W'(SETS));
  assign r_tag  = TAG_W'(r_ba / BA_W'(SETS));
  assign r_wsel = WSEL_W'((r_addr >> BO_W) % ADDR_W'(BLK_WORDS));

  logic [WAYS-1:0] hitv;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitv[w] = vld[r_idx][w] && (tags[r_idx][w] == r_tag);
  end

  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] pick;
  logic             have_free;
  always_comb begin
    hit_way   = '0;
    pick      = WAY_W'(lfsr % 16'(WAYS));
    have_free = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitv[w]) hit_way = WAY_W'(w);
      if (!vld[r_idx][w]) begin
        pick      = WAY_W'(w);
        have_free = 1'b1;
      end
    end
  end
  assign hit = |hitv;

  logic [BLK_W-1:0] hit_blk;
  logic [BLK_W-1:0] new_blk;
  assign hit_blk = data[r_idx][hit_way];

  always_comb begin
    new_blk = hit_blk;
    for (int b = 0; b < WORD_BYTES; b++)
      if (r_be[b]) new_blk[(int'(r_wsel) * WORD_BYTES + b) * 8 +: 8] = r_wd[b*8 +: 8];
  end

  assign req_ready  = (state == S_IDLE);
  assign resp_valid = (state == S_TAG) && hit;
  assign resp_rdata = hit_blk[int'(r_wsel) * WORD_W +: WORD_W];
  assign mem_req    = (state == S_WB) || (state == S_FILL);
  assign mem_we     = (state == S_WB);
  assign mem_addr   = (state == S_WB)
                    ? BA_W'(BA_W'(tags[r_idx][vic]) * BA_W'(SETS) + BA_W'(r_idx))
                    : r_ba;
  assign mem_wdata  = data[r_idx][vic];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      lfsr  <= LFSR_SEED;
      vic   <= '0;
      r_we  <= 1'b0;
      r_addr <= '0;
      r_be  <= '0;
      r_wd  <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        drt[s] <= '0;
      end
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      unique case (state)
        S_IDLE: if (req_valid) begin
          r_we   <= req_write;
          r_addr <= req_addr;
          r_be   <= req_be;
          r_wd   <= req_wdata;
          state  <= S_TAG;
        end
        S_TAG: if (hit) begin
          if (r_we) drt[r_idx][hit_way] <= 1'b1;
          state <= S_IDLE;
        end else begin
          vic   <= pick;
          state <= (!have_free && drt[r_idx][pick]) ? S_WB : S_FILL;
        end
        S_WB: if (mem_ready) begin
          drt[r_idx][vic] <= 1'b0;
          state <= S_FILL;
        end
        S_FILL: if (mem_ready) begin
          vld[r_idx][vic] <= 1'b1;
          drt[r_idx][vic] <= 1'b0;
          state <= S_TAG;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_TAG && hit && r_we)
      data[r_idx][hit_way] <= new_blk;
    else if (state == S_FILL && mem_ready) begin
      data[r_idx][vic] <= mem_rdata;
      tags[r_idx][vic] <= r_tag;
    end
  end
endmodule

module wb_cache_chk #(
  parameter int MA_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            resp_valid,
  input logic            mem_req,
  input logic            mem_we,
  input logic [MA_W-1:0] mem_addr,
  input logic            mem_ready
);
  a_r1_resp_single: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r3_resp_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !mem_req);

  a_r6_ready_low_in_miss: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r8_fill_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ready) |=> (mem_req && !mem_we));
endmodule

bind wb_cache wb_cache_chk #(.MA_W(ADDR_W - $clog2(WORD_BYTES * BLK_WORDS))) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_ready(mem_ready)
);

// File: tb/tb_wb_cache.sv
`timescale 1ns/1ps
module tb_wb_cache;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         req_valid = 0, req_write = 0;
  logic [15:0]  req_addr = '0;
  logic [7:0]   req_be = '0;
  logic [63:0]  req_wdata = '0;
  logic         req_ready, resp_valid;
  logic [63:0]  resp_rdata;
  logic         mem_req, mem_we;
  logic [11:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic         mem_ready = 0;
  logic [127:0] mem_rdata = '0;

  always #4 clk = ~clk;

  wb_cache dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  logic [127:0] memarr [4096];
  logic [127:0] gold   [4096];
  int wr_cnt = 0, rd_cnt = 0, mcnt = 0;
  int checks = 0, fails = 0, busy_bad = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ready <= 0; mcnt <= 0;
    end else if (mem_ready) begin
      mem_ready <= 0; mcnt <= 0;
    end else if (mem_req) begin
      if (mcnt == 2) begin
        mem_ready <= 1;
        if (mem_we) begin memarr[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
        else begin mem_rdata <= memarr[mem_addr]; rd_cnt <= rd_cnt + 1; end
      end else mcnt <= mcnt + 1;
    end
  end

  function automatic logic [127:0] init_blk(int i);
    logic [31:0] h = 32'(i) * 32'h9E3779B1 + 32'h1234567;
    return {h ^ 32'hA5A5A5A5, ~h, h + 32'd77, h};
  endfunction

  function automatic logic [63:0] gold_word(logic [15:0] a);
    return gold[a[15:4]][a[3]*64 +: 64];
  endfunction

  function automatic logic [127:0] merge(logic [127:0] blk, logic [15:0] a,
                                         logic [7:0] be, logic [63:0] wd);
    logic [127:0] r = blk;
    for (int b = 0; b < 8; b++)
      if (be[b]) r[(a[3]*8 + b)*8 +: 8] = wd[b*8 +: 8];
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [15:0] a, input logic [7:0] be,
                        input logic [63:0] wd, output logic [63:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1; req_write = we; req_addr = a; req_be = be; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (!resp_valid && req_ready) busy_bad++;
    end while (!resp_valid && lat < 1000);
    rd = resp_rdata;
    if (we) gold[a[15:4]] = merge(gold[a[15:4]], a, be, wd);
  endtask

  task automatic rd_check(logic [15:0] a, string req, output int lat, output int dw, output int dr);
    logic [63:0] d;
    int w0 = wr_cnt, r0 = rd_cnt;
    access(0, a, 8'h00, 64'h0, d, lat);
    dw = wr_cnt - w0; dr = rd_cnt - r0;
    check(d === gold_word(a), req, 128'(d), 128'(gold_word(a)));
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int lat, dw, dr, w0, r0;
    logic [63:0] d;
    void'($urandom(32'd2024));
    for (int i = 0; i < 4096; i++) begin
      memarr[i] = init_blk(i);
      gold[i]   = init_blk(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready === 1 && resp_valid === 0 && mem_req === 0, "R1 reset state",
          {resp_valid, mem_req}, 0);

    rd_check(16'h0000, "R6 read miss data", lat, dw, dr);
    check(dr == 1 && dw == 0, "R6 one fill, no write", dr, 1);
    rd_check(16'h0040, "R2 second block same set", lat, dw, dr);
    check(dr == 1, "R2 second fill", dr, 1);
    rd_check(16'h0000, "R10 first block kept", lat, dw, dr);
    check(lat == 1 && dr == 0 && dw == 0, "R10 hit after free-way fill", lat, 1);
    rd_check(16'h0048, "R2 upper word hit", lat, dw, dr);
    check(lat == 1 && dr == 0, "R3 hit latency", lat, 1);

    rd_check(16'h0080, "R9 replace clean data", lat, dw, dr);
    check(dw == 0 && dr == 1, "R9 clean victim no write", dw, 0);

    w0 = wr_cnt; r0 = rd_cnt;
    access(1, 16'h0088, 8'h0F, 64'hDEADBEEF_CAFEF00D, d, lat);
    check(lat == 1 && wr_cnt == w0 && rd_cnt == r0, "R5 write hit no memory", lat, 1);
    rd_check(16'h0088, "R4 masked bytes merged", lat, dw, dr);
    rd_check(16'h0080, "R4 other word intact", lat, dw, dr);
    access(1, 16'h0080, 8'h81, 64'h11223344_55667788, d, lat);
    rd_check(16'h0080, "R4 sparse mask", lat, dw, dr);

    w0 = wr_cnt; r0 = rd_cnt;
    access(1, 16'h0010, 8'hF0, 64'h0123456789ABCDEF, d, lat);
    check(rd_cnt - r0 == 1 && wr_cnt == w0, "R7 write miss fills first", rd_cnt - r0, 1);
    rd_check(16'h0010, "R7 allocated data merged", lat, dw, dr);
    check(lat == 1, "R7 block resident", lat, 1);
    access(1, 16'h0058, 8'h01, 64'h00000000000000AB, d, lat);

    rd_check(16'h0090, "R8 data after dirty eviction", lat, dw, dr);
    check(dw == 1 && dr == 1, "R8 single write-back", dw, 1);
    check(memarr[12'h001] === gold[12'h001] || memarr[12'h005] === gold[12'h005],
          "R8 victim contents in memory", memarr[12'h001], gold[12'h001]);
    rd_check(16'h0010, "R8 block 1 coherent", lat, dw, dr);
    rd_check(16'h0058, "R8 block 5 coherent", lat, dw, dr);

    for (int n = 0; n < 800; n++) begin
      logic [15:0] a = {8'h00, 4'($urandom_range(0, 15)), 1'($urandom), 3'b000};
      if ($urandom_range(0, 2) == 0) begin
        logic [7:0] be = 8'($urandom_range(1, 255));
        access(1, a, be, {$urandom, $urandom}, d, lat);
      end else begin
        rd_check(a, "R12 random read", lat, dw, dr);
      end
    end

    check(busy_bad == 0, "R6 ready low during miss", busy_bad, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule